// File: doc/BRIEF.md
# Single-Cycle Sorted Bucket Search Unit

This unit answers lookup questions about one hash bucket whose elements sit side by side in a row of comparison slots. The bucket is supplied from outside as a packed vector of elements kept in ascending order, together with an occupancy count. A query element goes to every slot in the same cycle, and each slot compares it with its stored element. The unit then returns a registered answer one clock after the request is accepted. The latency is the same for every bucket content and every slot count.

Three query kinds are supported. A membership test reports whether the element is present. A delete-position query names the slot that holds the element to be removed. An insert-position query names the slot in front of which the element would go so that the bucket stays sorted. Duplicates are allowed. The unit only reports positions. Moving elements after an insert or delete is the job of the logic that owns the bucket storage.

After reset a small controller spends one boot cycle with the request interface closed (state BOOT). It then moves to state RUN, where it accepts one request on every clock. BOOT to RUN is the only transition, and it is taken on the first clock edge after reset is released.

Top module: `hash_bucket_search`

## Requirements
- R1: In the first cycle after reset is released `req_ready` is 0 and a request offered then is not answered. From the following cycle on, `req_ready` stays 1.
- R2: During reset and in any cycle after one with no accepted request, `rsp_valid` is 0. A request accepted at a clock edge gives `rsp_valid`=1 after that edge, and `rsp_op` echoes the request's operation.
- R3: Membership (`req_op`=2'b00): `rsp_hit` is 1 exactly when some occupied slot equals the query. `rsp_index` is the lowest such slot.
- R4: Delete position (`req_op`=2'b10): this uses the same equality search and returns the lowest matching slot. With no match, `rsp_hit`=0 and `rsp_index`=0.
- R5: Insert position (`req_op`=2'b01): `rsp_index` is the lowest slot that is unoccupied or holds an element not less than the query. If every occupied slot is less and the bucket is full, the index equals SLOTS.
- R6: Slot i (bits [i*ELEM_W +: ELEM_W] of `bkt_elems`) is occupied only when i < `bkt_count`. An unoccupied slot never matches and ranks above any query. A count above SLOTS is treated as SLOTS.
- R7: For an insert-position query, `rsp_hit` is 1 exactly when the effective occupancy is below SLOTS, which means there is room.
- R8: Operation code 2'b11 is reserved. It is answered with `rsp_hit`=0 and `rsp_index`=0.
- R9: Requests on consecutive cycles are each answered in the cycle after their own acceptance, with no gaps.
- R10: When the query equals elements already present, the insert position is the lowest of the equal slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_ready | output | 1 | Request interface open |
| req_op | input | 2 | 00 member, 01 insert, 10 delete, 11 reserved |
| req_elem | input | ELEM_W | Query element (unsigned) |
| bkt_elems | input | SLOTS*ELEM_W | Bucket contents, slot 0 in the low bits, ascending |
| bkt_count | input | $clog2(SLOTS+1) | Number of occupied slots |
| rsp_valid | output | 1 | Answer present |
| rsp_op | output | 2 | Operation being answered |
| rsp_hit | output | 1 | Found (member/delete) or room available (insert) |
| rsp_index | output | $clog2(SLOTS+1) | Slot position result |

## Verification
The bench targets duplicated elements. A design that takes the highest matching slot instead of the lowest would report the wrong slot for both the equality searches and the insert position. The bench also queries the stored values that lie beyond the occupancy count. A design that ignores the count would find those values, and a design that does not clamp an oversized count would read past the bucket. The bench also covers a full bucket with a query larger than every element, where a narrow index would wrap to 0 or the room flag would wrongly stay set. Finally, it covers a request offered during the boot cycle, which must not be answered.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [1:0] {
        OP_MEMBER = 2'b00,
        OP_INSERT = 2'b01,
        OP_DELETE = 2'b10,
        OP_RSVD   = 2'b11
    } hbs_op_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } hbs_state_e;

endpackage

// File: rtl/hbs_cell.sv
module hbs_cell #(
    parameter int ELEM_W = 8
) (
    input  logic [ELEM_W-1:0] slot_elem,
    input  logic              slot_live,
    input  logic [ELEM_W-1:0] query,
    output logic              eq_hit,
    output logic              lt_hit
);

    // An unoccupied slot neither matches nor counts as smaller than the query.
    always_comb begin
        eq_hit = slot_live && (slot_elem == query);
        lt_hit = slot_live && (slot_elem <  query);
    end

endmodule

// File: rtl/hbs_first_set.sv
module hbs_first_set #(
    parameter int WIDTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/hash_bucket_search.sv
module hash_bucket_search
    import hbs_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int ELEM_W = 8,
    localparam int CNT_W = $clog2(SLOTS + 1),
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_op,
    input  logic [ELEM_W-1:0]       req_elem,
    input  logic [SLOTS*ELEM_W-1:0] bkt_elems,
    input  logic [CNT_W-1:0]        bkt_count,
    output logic                    rsp_valid,
    output logic [1:0]              rsp_op,
    output logic                    rsp_hit,
    output logic [CNT_W-1:0]        rsp_index
);

    localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

    hbs_state_e state_q, state_d;

    logic [CNT_W-1:0] eff_count;
    logic [SLOTS-1:0] live_vec;
    logic [SLOTS-1:0] eq_vec;
    logic [SLOTS-1:0] lt_vec;
    logic             eq_found;
    logic [IDX_W-1:0] eq_idx;
    logic             ge_found;
    logic [IDX_W-1:0] ge_idx;
    logic             accept;
    logic             hit_d;
    logic [CNT_W-1:0] index_d;

    // Occupancy clamped to the number of slots.
    always_comb begin
        eff_count = (bkt_count > SLOTS_C) ? SLOTS_C : bkt_count;
    end

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            assign live_vec[g] = (CNT_W'(g) < eff_count);
            hbs_cell #(.ELEM_W(ELEM_W)) u_cell (
                .slot_elem (bkt_elems[g*ELEM_W +: ELEM_W]),
                .slot_live (live_vec[g]),
                .query     (req_elem),
                .eq_hit    (eq_vec[g]),
                .lt_hit    (lt_vec[g])
            );
        end
    endgenerate

    hbs_first_set #(.WIDTH(SLOTS), .IDX_W(IDX_W)) u_eq_enc (
        .vec   (eq_vec),
        .found (eq_found),
        .idx   (eq_idx)
    );

    hbs_first_set #(.WIDTH(SLOTS), .IDX_W(IDX_W)) u_ge_enc (
        .vec   (~lt_vec),
        .found (ge_found),
        .idx   (ge_idx)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Next state and interface outputs.
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                req_ready = 1'b0;
                state_d   = ST_RUN;
            end
            ST_RUN: begin
                req_ready = 1'b1;
                state_d   = ST_RUN;
            end
            default: state_d = ST_BOOT;
        endcase
    end

    assign accept = req_valid && req_ready;

    // Result selection by operation.
    always_comb begin
        hit_d   = 1'b0;
        index_d = '0;
        unique case (hbs_op_e'(req_op))
            OP_MEMBER, OP_DELETE: begin
                hit_d   = eq_found;
                index_d = eq_found ? CNT_W'(eq_idx) : '0;
            end
            OP_INSERT: begin
                hit_d   = (eff_count < SLOTS_C);
                index_d = ge_found ? CNT_W'(ge_idx) : SLOTS_C;
            end
            OP_RSVD: begin
                hit_d   = 1'b0;
                index_d = '0;
            end
            default: begin
                hit_d   = 1'b0;
                index_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_op    <= 2'b00;
            rsp_hit   <= 1'b0;
            rsp_index <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_op    <= req_op;
                rsp_hit   <= hit_d;
                rsp_index <= index_d;
            end
        end
    end

endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
    parameter int SLOTS  = 8,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_op,
    input logic [CNT_W-1:0] bkt_count,
    input logic             rsp_valid,
    input logic [1:0]       rsp_op,
    input logic             rsp_hit,
    input logic [CNT_W-1:0] rsp_index
);

    localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

    a_r2_answer_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && rsp_op == $past(req_op)));

    a_r2_quiet_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);

    a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready);

    a_r4_miss_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && rsp_op != 2'b01) |-> (rsp_index == '0));

    a_r3_hit_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && rsp_op != 2'b01) |-> (rsp_index < SLOTS_C));

    a_r5_insert_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_op == 2'b01) |-> (rsp_index <= SLOTS_C));

    a_r7_room_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'b01) |=> (rsp_hit == ($past(bkt_count) < SLOTS_C)));

    a_r8_reserved_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_op == 2'b11) |-> (!rsp_hit && rsp_index == '0));

endmodule

bind hash_bucket_search hbs_checker #(.SLOTS(SLOTS)) u_hbs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .bkt_count (bkt_count),
    .rsp_valid (rsp_valid),
    .rsp_op    (rsp_op),
    .rsp_hit   (rsp_hit),
    .rsp_index (rsp_index)
);

// File: tb/hash_bucket_search_bench.sv
`timescale 1ns/1ps
module hash_bucket_search_bench;

    localparam int SLOTS  = 8;
    localparam int ELEM_W = 8;
    localparam int CNT_W  = 4;
    localparam int NV     = 16;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [1:0]              req_op = 2'b00;
    logic [ELEM_W-1:0]       req_elem = '0;
    logic [SLOTS*ELEM_W-1:0] bkt_elems;
    logic [CNT_W-1:0]        bkt_count = 4'd8;
    logic                    rsp_valid;
    logic [1:0]              rsp_op;
    logic                    rsp_hit;
    logic [CNT_W-1:0]        rsp_index;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    // Sorted bucket, slot 0 in the low bits: 10 20 20 30 40 50 60 70.
    assign bkt_elems = {8'd70, 8'd60, 8'd50, 8'd40, 8'd30, 8'd20, 8'd20, 8'd10};

    hash_bucket_search #(.SLOTS(SLOTS), .ELEM_W(ELEM_W)) u_hash_bucket_search (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_elem(req_elem), .bkt_elems(bkt_elems),
        .bkt_count(bkt_count), .rsp_valid(rsp_valid), .rsp_op(rsp_op),
        .rsp_hit(rsp_hit), .rsp_index(rsp_index)
    );

    // {op, elem, count, expected hit, expected index}
    localparam logic [18:0] VEC [NV] = '{
        {2'b00, 8'd30, 4'd8,  1'b1, 4'd3},  // R3 plain member
        {2'b00, 8'd20, 4'd8,  1'b1, 4'd1},  // R3 duplicate: lowest slot
        {2'b00, 8'd25, 4'd8,  1'b0, 4'd0},  // R3 absent
        {2'b00, 8'd70, 4'd6,  1'b0, 4'd0},  // R6 stored beyond count
        {2'b10, 8'd50, 4'd8,  1'b1, 4'd5},  // R4 delete found
        {2'b10, 8'd55, 4'd8,  1'b0, 4'd0},  // R4 delete absent
        {2'b01, 8'd25, 4'd8,  1'b0, 4'd3},  // R5 R7 full bucket, middle
        {2'b01, 8'd20, 4'd6,  1'b1, 4'd1},  // R10 before equal elements
        {2'b01, 8'd5,  4'd6,  1'b1, 4'd0},  // R5 beginning
        {2'b01, 8'd99, 4'd6,  1'b1, 4'd6},  // R6 first unoccupied slot
        {2'b01, 8'd99, 4'd8,  1'b0, 4'd8},  // R5 R7 end of full bucket
        {2'b01, 8'd99, 4'd12, 1'b0, 4'd8},  // R6 clamped count
        {2'b11, 8'd30, 4'd8,  1'b0, 4'd0},  // R8 reserved
        {2'b10, 8'd10, 4'd0,  1'b0, 4'd0},  // R6 empty bucket
        {2'b01, 8'd10, 4'd0,  1'b1, 4'd0},  // R7 empty bucket has room
        {2'b00, 8'd60, 4'd15, 1'b1, 4'd6}   // R6 oversize count, member
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'b00:   return "R3";
            2'b01:   return "R5";
            2'b10:   return "R4";
            default: return "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Reset state
        repeat (2) @(negedge clk);
        check("R2 rsp_valid in reset", int'(rsp_valid), 0);
        check("R1 ready in reset", int'(req_ready), 0);

        // Release, offer a request during the boot cycle
        rst_n     = 1'b1;
        req_valid = 1'b1;
        req_op    = 2'b00;
        req_elem  = 8'd30;
        bkt_count = 4'd8;
        #1;
        check("R1 ready in boot cycle", int'(req_ready), 0);
        @(negedge clk);
        check("R1 ready after boot", int'(req_ready), 1);
        check("R1 boot request not answered", int'(rsp_valid), 0);
        req_valid = 1'b0;

        // Back-to-back vectors (R9)
        for (int k = 0; k <= NV; k++) begin
            @(negedge clk);
            if (k > 0) begin
                logic [18:0] v;
                v = VEC[k-1];
                check("R9 rsp_valid", int'(rsp_valid), 1);
                check("R2 op echo", int'(rsp_op), int'(v[18:17]));
                check(op_req(v[18:17]), int'(rsp_hit), int'(v[4]));
                check(op_req(v[18:17]), int'(rsp_index), int'(v[3:0]));
                check("R1 ready stays", int'(req_ready), 1);
            end
            if (k < NV) begin
                req_valid = 1'b1;
                req_op    = VEC[k][18:17];
                req_elem  = VEC[k][16:9];
                bkt_count = VEC[k][8:5];
            end else begin
                req_valid = 1'b0;
            end
        end

        // Idle cycle: no answer
        @(negedge clk);
        check("R2 idle no response", int'(rsp_valid), 0);

        // Single delete of the top element after a gap
        req_valid = 1'b1;
        req_op    = 2'b10;
        req_elem  = 8'd70;
        bkt_count = 4'd8;
        @(negedge clk);
        req_valid = 1'b0;
        check("R4 delete last slot hit", int'(rsp_hit), 1);
        check("R4 delete last slot index", int'(rsp_index), 7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule